// File: doc/BRIEF.md
# Ramped Digital Soft Mute

This block scales a stereo stream of signed samples by a gain that moves in small linear steps. A mute request lowers the gain step by step to silence, and a release raises it step by step back to unity, so the output never jumps. The gain is an index from 0 to 1024 that changes by one step on each frame strobe. One frame strobe arrives per left/right sample period. The output is the input times the index divided by 1024, rounded toward zero.

The mute level is read only on frame strobes. If the direction reverses partway through a fade, the index turns around from its present value. A climb that starts after k frames of fade-down therefore reaches unity again after exactly k frames. The block sits in the digital path before any conversion stage. Each processed frame comes out one clock cycle after its strobe, marked by a valid pulse.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset the gain index is 1024 (unity), `out_vld` is 0 and both outputs are 0.
- R2: `out_vld` is 1 in the cycle right after a cycle with `frame_stb` high, and 0 in every other cycle. The outputs update only together with `out_vld`.
- R3: On each strobe with `mute_req` high, the index falls by one, stopping at 0. From unity, 1024 muted frames reach index 0. At index 0 both outputs are exactly 0.
- R4: At index 1024, each output equals its input bit for bit.
- R5: On each strobe with `mute_req` low, the index rises by one, stopping at 1024. From 0, 1024 unmuted frames restore unity.
- R6: If mute is released after k frames of fade-down from unity (k < 1024), the output equals the input again on the frame after the k-th unmuted frame and not before. The index never changes by more than one step per frame.
- R7: Each frame's output is (sample × g) / 1024, rounded toward zero and held within the signed 24-bit range. Here g is the index before that frame's update.
- R8: `mute_req` and the sample inputs have no effect in cycles without `frame_stb`. Between strobes the index holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_req | input | 1 | 1 = fade toward silence, 0 = fade toward unity |
| frame_stb | input | 1 | One-cycle pulse per stereo frame |
| in_l | input | 24 | Left sample, signed |
| in_r | input | 24 | Right sample, signed |
| out_l | output | 24 | Attenuated left sample, signed |
| out_r | output | 24 | Attenuated right sample, signed |
| out_vld | output | 1 | Output frame valid, one cycle after `frame_stb` |

## Verification
The hardest case to reach is a reversal deep inside a fade. The exact frame on which the output first equals its input again is the only port-visible sign that the climb took the same number of frames as the fall. The stimulus fades down a chosen number of frames and then releases while feeding the largest positive sample. At that sample, any index below unity gives a visibly smaller output. This locates the return frame exactly. Long random runs with rare mute flips, mute toggles between strobes, and extreme sample values then cover reversals at many points along the ramp.

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DW = 24,
  parameter int STEPS_LOG2 = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mute_req,
  input  logic                 frame_stb,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic                 out_vld
);
  localparam int GW = STEPS_LOG2 + 1;
  localparam int PW = DW + GW + 1;
  localparam logic [GW-1:0] FULL = {1'b1, {STEPS_LOG2{1'b0}}};
  localparam logic signed [PW-1:0] BIAS = {{(PW-STEPS_LOG2){1'b0}}, {STEPS_LOG2{1'b1}}};
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [GW-1:0] gain;
  logic signed [PW-1:0] gain_s, prod_l, prod_r;

  assign gain_s = PW'($signed({1'b0, gain}));
  assign prod_l = PW'(in_l) * gain_s;
  assign prod_r = PW'(in_r) * gain_s;

  function automatic logic signed [DW-1:0] scale(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] q;
    q = (p[PW-1] ? p + BIAS : p) >>> STEPS_LOG2;
    if (q > MAXV)      return MAXV[DW-1:0];
    else if (q < MINV) return MINV[DW-1:0];
    else               return q[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain <= FULL;
    end else if (frame_stb) begin
      if (mute_req && gain != '0)      gain <= gain - 1'b1;
      else if (!mute_req && gain != FULL) gain <= gain + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_l   <= '0;
      out_r   <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= frame_stb;
      if (frame_stb) begin
        out_l <= scale(prod_l);
        out_r <= scale(prod_r);
      end
    end
  end
endmodule

module soft_mute_ramp_chk #(
  parameter int DW = 24,
  parameter int GW = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mute_req,
  input logic                 frame_stb,
  input logic [GW-1:0]        gain,
  input logic signed [DW-1:0] in_l,
  input logic signed [DW-1:0] in_r,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic                 out_vld
);
  localparam logic [GW-1:0] FULL = {1'b1, {(GW-1){1'b0}}};

  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n) frame_stb |=> out_vld); // R2
  AST_VLD_ONLY_STB: assert property (@(posedge clk) disable iff (!rst_n) !frame_stb |=> !out_vld); // R2
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) gain <= FULL); // R7
  AST_GAIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (frame_stb && mute_req && gain != '0) |=> gain == $past(gain) - 1'b1); // R3
  AST_GAIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) (frame_stb && mute_req && gain == '0) |=> gain == '0); // R3
  AST_GAIN_UP: assert property (@(posedge clk) disable iff (!rst_n) (frame_stb && !mute_req && gain != FULL) |=> gain == $past(gain) + 1'b1); // R5
  AST_GAIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n) (frame_stb && !mute_req && gain == FULL) |=> gain == FULL); // R5
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_stb |=> $stable(gain)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_stb |=> ($stable(out_l) && $stable(out_r))); // R8
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n) (frame_stb && gain == '0) |=> (out_l == '0 && out_r == '0)); // R3
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n) (frame_stb && gain == FULL) |=> (out_l == $past(in_l) && out_r == $past(in_r))); // R4
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .frame_stb(frame_stb),
  .gain(gain), .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
  .out_vld(out_vld)
);

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute_req = 1'b0;
  logic frame_stb = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic signed [23:0] out_l, out_r;
  logic out_vld;

  int checks = 0;
  int errors = 0;
  int mg = 1024;
  bit done = 0;

  localparam logic signed [23:0] SMAX = 24'sh7FFFFF;
  localparam logic signed [23:0] SMIN = 24'sh800000;

  always #4 clk = ~clk;

  soft_mute_ramp i_soft_mute_ramp (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .frame_stb(frame_stb),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r), .out_vld(out_vld)
  );

  function automatic logic signed [23:0] expect_att(input logic signed [23:0] s, input int g);
    longint p;
    p = longint'(s) * longint'(g);
    return 24'(p / 1024);
  endfunction

  function automatic logic signed [23:0] rnd_sample();
    int sel;
    sel = int'($urandom % 8);
    if (sel == 0) return SMAX;
    if (sel == 1) return SMIN;
    return 24'($urandom);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input bit m, input logic signed [23:0] l, input logic signed [23:0] r, input int idle);
    logic signed [23:0] el, er;
    @(negedge clk);
    mute_req = m; frame_stb = 1'b1; in_l = l; in_r = r;
    @(negedge clk);
    frame_stb = 1'b0;
    el = expect_att(l, mg);
    er = expect_att(r, mg);
    check(out_vld == 1'b1, "R2 vld after strobe", longint'(out_vld), 1);
    check(out_l == el, "R7 left", longint'(out_l), longint'(el));
    check(out_r == er, "R7 right", longint'(out_r), longint'(er));
    if (m) mg = (mg > 0) ? mg - 1 : 0;
    else   mg = (mg < 1024) ? mg + 1 : 1024;
    for (int i = 0; i < idle; i++) begin
      mute_req = 1'($urandom);
      in_l = rnd_sample(); in_r = rnd_sample();
      @(negedge clk);
      check(out_vld == 1'b0, "R2 no vld without strobe", longint'(out_vld), 0);
      check(out_l == el && out_r == er, "R8 outputs hold", longint'(out_l), longint'(el));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R1 reset vld", longint'(out_vld), 0);
    check(out_l == 0 && out_r == 0, "R1 reset outputs", longint'(out_l), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R4: unity gain straight after reset, bit-exact passthrough
    frame(1'b0, SMIN, SMAX, 0);
    check(out_l == SMIN && out_r == SMAX, "R1 R4 unity after reset", longint'(out_l), longint'(SMIN));
    for (int i = 0; i < 40; i++) frame(1'b0, rnd_sample(), rnd_sample(), int'($urandom % 3));

    // R3: full fade to silence, then held at zero
    for (int i = 0; i < 1024; i++) frame(1'b1, rnd_sample(), rnd_sample(), int'($urandom % 2));
    frame(1'b1, SMAX, SMIN, 0);
    check(out_l == 0 && out_r == 0, "R3 silence after 1024 frames", longint'(out_l), 0);
    frame(1'b1, SMIN, SMAX, 0);
    check(out_l == 0 && out_r == 0, "R3 floor holds", longint'(out_l), 0);

    // R5: climb from silence takes 1024 frames
    for (int i = 0; i < 1023; i++) frame(1'b0, rnd_sample(), rnd_sample(), int'($urandom % 2));
    frame(1'b0, SMAX, SMAX, 0);
    check(out_l != SMAX, "R5 not yet unity after 1023 frames", longint'(out_l), longint'(SMAX) - 1);
    frame(1'b0, SMAX, SMIN, 0);
    check(out_l == SMAX && out_r == SMIN, "R5 unity after 1024 frames", longint'(out_l), longint'(SMAX));

    // R6: reversal mid-fade, climb back equals frames spent falling
    for (int i = 0; i < 300; i++) frame(1'b1, rnd_sample(), rnd_sample(), 0);
    for (int i = 0; i < 299; i++) frame(1'b0, rnd_sample(), rnd_sample(), int'($urandom % 2));
    frame(1'b0, SMAX, SMAX, 0);
    check(out_l != SMAX, "R6 below unity on k-th climb frame", longint'(out_l), longint'(SMAX) - 1);
    frame(1'b0, SMAX, SMAX, 0);
    check(out_l == SMAX, "R6 unity after k climb frames", longint'(out_l), longint'(SMAX));

    // R8: mute toggled only between strobes leaves the gain unchanged
    for (int i = 0; i < 20; i++) frame(1'b0, SMAX, SMIN, 3);
    check(out_l == SMAX && out_r == SMIN, "R8 idle mute ignored", longint'(out_l), longint'(SMAX));

    // random mix: rare mute flips, reversals at many points along the ramp
    begin
      bit m = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 150 == 0) m = ~m;
        frame(m, rnd_sample(), rnd_sample(), int'($urandom % 3));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule